// File: doc/BRIEF.md
# Letterbox Black-Line Detector

The block watches a luma pixel stream and sorts every active video line into black or non-black. A line counts as non-black only when enough pixels inside a central window, which skips a configurable margin at both edges, are brighter than a configurable threshold. This window lets a bright logo placed at the very left or right of a letterbox bar go unnoticed, while subtitle text inside the bar still makes its line non-black.

For each field the block counts two runs. One is the black lines from the top of the field up to the first non-black line. The other is the black lines that end the field. At every field start the block latches both counts, the larger of the two, and a dark-scene flag. The flag is set when no pixel of the field reached a second luma threshold. An external controller reads these values once per field and uses the larger count as the basis for vertical zoom. Because the larger count is used, a subtitle band on one side does not shrink the result.

Two state machines drive the block. The line machine has the states LN_IDLE (no pixel since the last line boundary) and LN_OPEN (the current line has carried at least one valid pixel). Its transitions are: pixel-arrives (LN_IDLE to LN_OPEN), boundary-with-pixel (LN_OPEN stays LN_OPEN for the new line), and boundary-without-pixel (LN_OPEN to LN_IDLE). The run machine has the states TRK_WAIT (before the first field start), TRK_TOP (all lines so far in the field were black) and TRK_BODY (a non-black line has been seen). Its transitions are: first-field (TRK_WAIT to TRK_TOP), bright-line (TRK_TOP to TRK_BODY), and new-field (TRK_TOP or TRK_BODY to TRK_TOP).

Top module: `lbox_detect`

## Requirements
- R1: After reset all four outputs are 0, and they stay 0 until the second field start, because the first field start only opens a field and latches nothing.
- R2: A line is non-black exactly when the number of its valid pixels that have luma strictly greater than cfg_bright_thr and a pixel index i (counting valid pixels from 0 at line start) with cfg_margin <= i < cfg_line_width - cfg_margin is at least cfg_min_bright (cfg_min_bright >= 1).
- R3: A line whose bright pixels all fall at index < cfg_margin or >= cfg_line_width - cfg_margin is black.
- R4: top_lines is the number of black lines from the start of the field up to, but not including, its first non-black line.
- R5: bottom_lines is the number of consecutive black lines that end the field. Any non-black line resets this run to 0.
- R6: zoom_lines equals the larger of top_lines and bottom_lines.
- R7: dark_scene is 1 exactly when every valid pixel of the field has luma strictly below cfg_dark_thr.
- R8: The outputs change only in the cycle after a field_start. At all other times they hold their values.
- R9: A line in which no valid pixel arrived is not counted and does not break a run.
- R10: Both counts saturate at 2^LINE_W-1 and do not wrap.
- R11: A field_start closes the line in progress, and that line is included in the latched counts. A pixel presented in the same cycle as field_start belongs to the new field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_luma | input | LUMA_W | Luma of the current pixel |
| pix_valid | input | 1 | pix_luma carries a pixel this cycle |
| line_start | input | 1 | Pulse that closes the previous line; the pixel in this cycle is index 0 of the new line |
| field_start | input | 1 | Pulse that closes the field, latches results and opens a new field |
| cfg_bright_thr | input | LUMA_W | Luma above which a window pixel is bright |
| cfg_dark_thr | input | LUMA_W | Field peak below which the scene is dark |
| cfg_margin | input | PIX_W | Pixels ignored at each line edge |
| cfg_line_width | input | PIX_W | Active pixels per line |
| cfg_min_bright | input | PIX_W | Bright window pixels that make a line non-black |
| top_lines | output | LINE_W | Latched top black run |
| bottom_lines | output | LINE_W | Latched bottom black run |
| zoom_lines | output | LINE_W | Larger of the two runs |
| dark_scene | output | 1 | Latched dark-picture flag |

## Verification
Closing a field and starting the next one can happen in the same cycle: a field_start may arrive together with line_start and the first pixel of the new field. The bench provokes this by making the outgoing field dark and ending it with a black line, then presenting a bright first pixel together with field_start. It judges the result by checking that the latched bottom count includes the outgoing line and that dark_scene is still 1, because the bright pixel belongs to the new field and must not affect the old one. The same cycle is also mixed at random into randomized fields and compared against the bench model.

// File: rtl/lbox_pkg.sv
package lbox_pkg;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_OPEN = 1'b1
    } line_state_e;

    typedef enum logic [1:0] {
        TRK_WAIT = 2'd0,
        TRK_TOP  = 2'd1,
        TRK_BODY = 2'd2
    } trk_state_e;

endpackage

// File: rtl/lbox_line_classifier.sv
module lbox_line_classifier
    import lbox_pkg::*;
#(
    parameter int LUMA_W = 8,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUMA_W-1:0] pix_luma,
    input  logic              pix_valid,
    input  logic              line_start,
    input  logic              field_start,
    input  logic [LUMA_W-1:0] cfg_bright_thr,
    input  logic [PIX_W-1:0]  cfg_margin,
    input  logic [PIX_W-1:0]  cfg_line_width,
    input  logic [PIX_W-1:0]  cfg_min_bright,
    output logic              line_done,
    output logic              line_black
);

    localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};
    localparam logic [PIX_W-1:0] PIX_ONE = PIX_W'(1);

    line_state_e       st_q, st_d;
    logic              boundary;
    logic [PIX_W-1:0]  idx_q;
    logic [PIX_W-1:0]  cnt_q;
    logic [PIX_W-1:0]  cur_idx;
    logic [PIX_W:0]    right_edge;
    logic              in_window;
    logic              hit;

    assign boundary = line_start | field_start;

    // Pixel position and window test for the pixel in this cycle
    always_comb begin
        cur_idx    = boundary ? '0 : idx_q;
        right_edge = {1'b0, cur_idx} + {1'b0, cfg_margin};
        in_window  = (cur_idx >= cfg_margin) && (right_edge < {1'b0, cfg_line_width});
        hit        = pix_valid && in_window && (pix_luma > cfg_bright_thr);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_IDLE: st_d = pix_valid ? LN_OPEN : LN_IDLE;
            LN_OPEN: begin
                if (boundary) begin
                    st_d = pix_valid ? LN_OPEN : LN_IDLE;
                end
            end
            default: st_d = LN_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        line_done  = boundary && (st_q == LN_OPEN);
        line_black = (cnt_q < cfg_min_bright);
    end

    // Pixel index and bright-pixel count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (boundary) begin
            idx_q <= pix_valid ? PIX_ONE : '0;
            cnt_q <= hit ? PIX_ONE : '0;
        end else if (pix_valid) begin
            if (idx_q != PIX_MAX) begin
                idx_q <= idx_q + PIX_ONE;
            end
            if (hit && (cnt_q != PIX_MAX)) begin
                cnt_q <= cnt_q + PIX_ONE;
            end
        end
    end

endmodule

// File: rtl/lbox_run_tracker.sv
module lbox_run_tracker
    import lbox_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_done,
    input  logic              line_black,
    output logic              fld_done,
    output logic [LINE_W-1:0] fld_top,
    output logic [LINE_W-1:0] fld_bot
);

    localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

    trk_state_e        st_q, st_d, st_nx;
    logic [LINE_W-1:0] top_q, bot_q;
    logic [LINE_W-1:0] top_d, bot_d;

    function automatic logic [LINE_W-1:0] sat_inc(input logic [LINE_W-1:0] v);
        return (v == CNT_MAX) ? v : v + LINE_W'(1);
    endfunction

    // State and run registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TRK_WAIT;
            top_q <= '0;
            bot_q <= '0;
        end else begin
            st_q  <= st_nx;
            top_q <= field_start ? '0 : top_d;
            bot_q <= field_start ? '0 : bot_d;
        end
    end

    // Line accounting (includes a line closed by field_start)
    always_comb begin
        st_d  = st_q;
        top_d = top_q;
        bot_d = bot_q;
        unique case (st_q)
            TRK_WAIT: begin
                top_d = '0;
                bot_d = '0;
            end
            TRK_TOP: begin
                if (line_done) begin
                    if (line_black) begin
                        top_d = sat_inc(top_q);
                        bot_d = sat_inc(bot_q);
                    end else begin
                        st_d  = TRK_BODY;
                        bot_d = '0;
                    end
                end
            end
            TRK_BODY: begin
                if (line_done) begin
                    bot_d = line_black ? sat_inc(bot_q) : '0;
                end
            end
            default: st_d = TRK_WAIT;
        endcase
        st_nx = field_start ? TRK_TOP : st_d;
    end

    // Field results
    always_comb begin
        fld_done = field_start && (st_q != TRK_WAIT);
        fld_top  = top_d;
        fld_bot  = bot_d;
    end

endmodule

// File: rtl/lbox_peak_meter.sv
module lbox_peak_meter #(
    parameter int LUMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUMA_W-1:0] pix_luma,
    input  logic              pix_valid,
    input  logic              field_start,
    output logic [LUMA_W-1:0] fld_peak
);

    logic [LUMA_W-1:0] peak_q;

    assign fld_peak = peak_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else if (field_start) begin
            peak_q <= pix_valid ? pix_luma : '0;
        end else if (pix_valid && (pix_luma > peak_q)) begin
            peak_q <= pix_luma;
        end
    end

endmodule

// File: rtl/lbox_detect.sv
module lbox_detect
    import lbox_pkg::*;
#(
    parameter int LUMA_W = 8,
    parameter int PIX_W  = 12,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUMA_W-1:0] pix_luma,
    input  logic              pix_valid,
    input  logic              line_start,
    input  logic              field_start,
    input  logic [LUMA_W-1:0] cfg_bright_thr,
    input  logic [LUMA_W-1:0] cfg_dark_thr,
    input  logic [PIX_W-1:0]  cfg_margin,
    input  logic [PIX_W-1:0]  cfg_line_width,
    input  logic [PIX_W-1:0]  cfg_min_bright,
    output logic [LINE_W-1:0] top_lines,
    output logic [LINE_W-1:0] bottom_lines,
    output logic [LINE_W-1:0] zoom_lines,
    output logic              dark_scene
);

    logic              line_done;
    logic              line_black;
    logic              fld_done;
    logic [LINE_W-1:0] fld_top;
    logic [LINE_W-1:0] fld_bot;
    logic [LINE_W-1:0] fld_max;
    logic [LUMA_W-1:0] fld_peak;

    lbox_line_classifier #(
        .LUMA_W (LUMA_W),
        .PIX_W  (PIX_W)
    ) u_class (
        .clk            (clk),
        .rst_n          (rst_n),
        .pix_luma       (pix_luma),
        .pix_valid      (pix_valid),
        .line_start     (line_start),
        .field_start    (field_start),
        .cfg_bright_thr (cfg_bright_thr),
        .cfg_margin     (cfg_margin),
        .cfg_line_width (cfg_line_width),
        .cfg_min_bright (cfg_min_bright),
        .line_done      (line_done),
        .line_black     (line_black)
    );

    lbox_run_tracker #(
        .LINE_W (LINE_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .line_done   (line_done),
        .line_black  (line_black),
        .fld_done    (fld_done),
        .fld_top     (fld_top),
        .fld_bot     (fld_bot)
    );

    lbox_peak_meter #(
        .LUMA_W (LUMA_W)
    ) u_peak (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_luma    (pix_luma),
        .pix_valid   (pix_valid),
        .field_start (field_start),
        .fld_peak    (fld_peak)
    );

    assign fld_max = (fld_top >= fld_bot) ? fld_top : fld_bot;

    // Result registers, written once per field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_lines    <= '0;
            bottom_lines <= '0;
            zoom_lines   <= '0;
            dark_scene   <= 1'b0;
        end else if (fld_done) begin
            top_lines    <= fld_top;
            bottom_lines <= fld_bot;
            zoom_lines   <= fld_max;
            dark_scene   <= (fld_peak < cfg_dark_thr);
        end
    end

endmodule

// File: rtl/lbox_detect_chk.sv
module lbox_detect_chk #(
    parameter int LUMA_W = 8,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              line_start,
    input logic              field_start,
    input logic [LINE_W-1:0] top_lines,
    input logic [LINE_W-1:0] bottom_lines,
    input logic [LINE_W-1:0] zoom_lines,
    input logic              dark_scene
);

    localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

    logic              seen_q;
    logic              open_q;
    logic              edge_now;
    logic [LINE_W-1:0] lines_q;
    logic [LINE_W-1:0] lines_now;
    logic [LINE_W-1:0] snap_q;

    assign edge_now  = line_start | field_start;
    assign lines_now = (edge_now && open_q && (lines_q != LMAX)) ? lines_q + LINE_W'(1) : lines_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            open_q  <= 1'b0;
            lines_q <= '0;
            snap_q  <= '0;
        end else begin
            if (field_start) begin
                seen_q  <= 1'b1;
                lines_q <= '0;
                snap_q  <= lines_now;
            end else begin
                lines_q <= lines_now;
            end
            open_q <= edge_now ? pix_valid : (open_q | pix_valid);
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (top_lines == '0 && bottom_lines == '0 && zoom_lines == '0 && !dark_scene)); // R1

    AST_TOP_WITHIN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && seen_q) |=> (top_lines <= snap_q)); // R4

    AST_BOT_WITHIN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && seen_q) |=> (bottom_lines <= snap_q)); // R5

    AST_ZOOM_IS_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
        (zoom_lines >= top_lines) && (zoom_lines >= bottom_lines) &&
        ((zoom_lines == top_lines) || (zoom_lines == bottom_lines))); // R6

    AST_HOLD_BETWEEN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> ($stable(top_lines) && $stable(bottom_lines) &&
                          $stable(zoom_lines) && $stable(dark_scene))); // R8

endmodule

bind lbox_detect lbox_detect_chk #(
    .LUMA_W (LUMA_W),
    .LINE_W (LINE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .line_start   (line_start),
    .field_start  (field_start),
    .top_lines    (top_lines),
    .bottom_lines (bottom_lines),
    .zoom_lines   (zoom_lines),
    .dark_scene   (dark_scene)
);

// File: tb/tb_lbox_detect.sv
`timescale 1ns/100ps
module tb_lbox_detect;

    localparam int LUMA_W = 8;
    localparam int PIX_W  = 12;
    localparam int LINE_W = 6;
    localparam int WIDTH  = 32;
    localparam int MARGIN = 4;
    localparam int THR    = 32;
    localparam int MINB   = 3;
    localparam int DARKT  = 40;
    localparam int CMAX   = (1 << LINE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [LUMA_W-1:0] pix_luma;
    logic              pix_valid;
    logic              line_start;
    logic              field_start;
    logic [LINE_W-1:0] top_lines, bottom_lines, zoom_lines;
    logic              dark_scene;

    always #2.5 clk = ~clk;

    lbox_detect #(.LUMA_W(LUMA_W), .PIX_W(PIX_W), .LINE_W(LINE_W)) dut (
        .clk(clk), .rst_n(rst_n), .pix_luma(pix_luma), .pix_valid(pix_valid),
        .line_start(line_start), .field_start(field_start),
        .cfg_bright_thr(LUMA_W'(THR)), .cfg_dark_thr(LUMA_W'(DARKT)),
        .cfg_margin(PIX_W'(MARGIN)), .cfg_line_width(PIX_W'(WIDTH)),
        .cfg_min_bright(PIX_W'(MINB)),
        .top_lines(top_lines), .bottom_lines(bottom_lines),
        .zoom_lines(zoom_lines), .dark_scene(dark_scene)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    int m_top, m_bot, m_peak;
    bit m_body, m_started, m_pend, m_pend_black;
    int exp_top, exp_bot, exp_max;
    bit exp_dark;
    logic [7:0] lbuf [WIDTH];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Line verdict from R2: bright window pixels counted against MINB
    function automatic bit buf_black();
        int n = 0;
        for (int i = MARGIN; i < WIDTH - MARGIN; i++)
            if (lbuf[i] > THR) n++;
        return n < MINB;
    endfunction

    function automatic int sat(int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic fill_black();
        for (int i = 0; i < WIDTH; i++) lbuf[i] = 8'($urandom % (THR + 1));
    endtask
    task automatic fill_logo();
        fill_black();
        for (int i = 0; i < MARGIN; i++) begin
            lbuf[i] = 8'(200 + $urandom % 50);
            lbuf[WIDTH-1-i] = 8'(200 + $urandom % 50);
        end
    endtask
    task automatic fill_run(int n, int val);
        int st;
        fill_black();
        st = MARGIN + int'($urandom % (WIDTH - 2*MARGIN - n + 1));
        for (int i = 0; i < n; i++) lbuf[st+i] = 8'(val);
    endtask
    task automatic fill_flat(int val);
        for (int i = 0; i < WIDTH; i++) lbuf[i] = 8'(val);
    endtask

    task automatic apply_pending();
        if (m_pend && m_started) begin
            if (m_pend_black) begin
                if (!m_body) m_top = sat(m_top + 1);
                m_bot = sat(m_bot + 1);
            end else begin
                m_body = 1;
                m_bot  = 0;
            end
        end
        m_pend = 0;
    endtask

    task automatic latch_model();
        if (m_started) begin
            exp_top  = m_top;
            exp_bot  = m_bot;
            exp_max  = (m_top > m_bot) ? m_top : m_bot;
            exp_dark = (m_peak < DARKT);
        end
        m_started = 1;
        m_top = 0; m_bot = 0; m_body = 0; m_peak = 0;
    endtask

    task automatic check_results(string tag);
        check({"R4 top ", tag}, int'(top_lines), exp_top);
        check({"R5 bottom ", tag}, int'(bottom_lines), exp_bot);
        check({"R6 zoom ", tag}, int'(zoom_lines), exp_max);
        check({"R7 dark ", tag}, int'(dark_scene), int'(exp_dark));
    endtask

    // Drives one line from lbuf; with_fs puts field_start on its first cycle (R11)
    task automatic drive_line(bit empty, bit gaps, bit with_fs);
        apply_pending();
        if (with_fs) latch_model();
        if (empty) begin
            line_start = 1; field_start = with_fs; pix_valid = 0;
            @(negedge clk);
            line_start = 0; field_start = 0;
            if (with_fs) check_results("fs+line");
        end else begin
            for (int i = 0; i < WIDTH; i++) begin
                line_start  = (i == 0);
                field_start = with_fs && (i == 0);
                pix_valid   = 1;
                pix_luma    = lbuf[i];
                if (int'(lbuf[i]) > m_peak) m_peak = int'(lbuf[i]);
                @(negedge clk);
                if (with_fs && i == 0) begin
                    field_start = 0;
                    check_results("fs+line");
                end
                if (gaps && ($urandom % 4 == 0)) begin
                    line_start = 0; pix_valid = 0;
                    @(negedge clk);
                end
            end
            line_start = 0; pix_valid = 0;
            m_pend = 1;
            m_pend_black = buf_black();
        end
    endtask

    task automatic field_edge(string tag);
        apply_pending();
        latch_model();
        field_start = 1; line_start = 0; pix_valid = 0;
        @(negedge clk);
        field_start = 0;
        check_results(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int seed_use;
        seed_use = int'($urandom(32'd2024));
        rst_n = 0; pix_luma = 0; pix_valid = 0; line_start = 0; field_start = 0;
        m_top = 0; m_bot = 0; m_peak = 0; m_body = 0; m_started = 0; m_pend = 0;
        exp_top = 0; exp_bot = 0; exp_max = 0; exp_dark = 0;
        repeat (3) @(negedge clk);
        check("R1 reset top", int'(top_lines), 0);
        check("R1 reset bottom", int'(bottom_lines), 0);
        check("R1 reset zoom", int'(zoom_lines), 0);
        check("R1 reset dark", int'(dark_scene), 0);
        rst_n = 1;
        @(negedge clk);

        // R1: lines before any field start, then the opening field start
        fill_black(); drive_line(0, 0, 0);
        fill_run(5, 220); drive_line(0, 0, 0);
        check("R1 pre-field zoom", int'(zoom_lines), 0);
        field_edge("first");

        // R2/R3: logo line black, MINB-1 window pixels black, subtitle non-black
        fill_black(); drive_line(0, 0, 0);
        fill_black(); drive_line(0, 1, 0);
        fill_logo();  drive_line(0, 0, 0);
        fill_run(MINB-1, 255); drive_line(0, 0, 0);
        fill_run(MINB, THR+1); drive_line(0, 0, 0);
        fill_black(); drive_line(0, 0, 0);
        fill_logo();  drive_line(0, 0, 0);
        field_edge("directed A");
        check("R3 logo lines stay black in top run", int'(top_lines), 4);
        check("R2 MINB-1 bright pixels is black", int'(top_lines), 4);
        check("R5 trailing run after subtitle", int'(bottom_lines), 2);

        // R9: empty lines neither count nor break a run
        fill_black(); drive_line(0, 0, 0);
        drive_line(1, 0, 0);
        fill_black(); drive_line(0, 0, 0);
        fill_run(8, 180); drive_line(0, 0, 0);
        fill_black(); drive_line(0, 0, 0);
        drive_line(1, 0, 0);
        field_edge("directed B");
        check("R9 empty line skipped top", int'(top_lines), 2);
        check("R9 empty line skipped bottom", int'(bottom_lines), 1);

        // R7/R11: dark field ended by field_start with a bright first pixel
        fill_flat(DARKT-1); drive_line(0, 0, 0);
        fill_flat(DARKT-1); drive_line(0, 0, 0);
        fill_black(); drive_line(0, 0, 0);
        fill_flat(250); drive_line(0, 0, 1);
        check("R11 closing line counted", int'(bottom_lines), 1);
        check("R11 new-field pixel excluded from dark", int'(dark_scene), 1);
        fill_black(); drive_line(0, 0, 0);
        check("R8 outputs hold mid-field", int'(bottom_lines), 1);
        check("R8 dark holds mid-field", int'(dark_scene), 1);
        fill_black(); drive_line(0, 0, 0);
        field_edge("directed D");
        check("R7 bright field not dark", int'(dark_scene), 0);

        // R7: peak exactly at the dark threshold is not dark
        fill_flat(DARKT); drive_line(0, 0, 0);
        field_edge("peak at threshold");
        check("R7 peak equal threshold", int'(dark_scene), 0);

        // R10: saturation
        for (int k = 0; k < CMAX + 7; k++) begin
            fill_black(); drive_line(0, 0, 0);
        end
        field_edge("saturation");
        check("R10 top saturates", int'(top_lines), CMAX);
        check("R10 bottom saturates", int'(bottom_lines), CMAX);

        // Random fields
        for (int f = 0; f < 25; f++) begin
            int nl = 3 + int'($urandom % 10);
            for (int l = 0; l < nl; l++) begin
                int kind = int'($urandom % 6);
                bit fs_here = (l == 0) && (f % 2 == 1);
                case (kind)
                    0, 1: fill_black();
                    2: fill_logo();
                    3: fill_run(MINB-1, 150 + int'($urandom % 100));
                    4: fill_run(MINB + int'($urandom % 5), THR + 1 + int'($urandom % 100));
                    default: fill_black();
                endcase
                drive_line(kind == 5 && ($urandom % 2 == 0), 1, fs_here);
            end
            if (f % 2 == 0) field_edge("random");
        end
        field_edge("final");

        finish_up();
    end

endmodule